// File: doc/BRIEF.md
# Control Packet Dispatcher with Seconds Clock

This block sits behind a byte-serial transfer engine. It takes in one complete packet at a time on a valid/ready byte stream and, where the packet calls for an answer, returns a reply packet on a second valid/ready byte stream. Byte 0 of a packet gives its class. Only the control class (code 1) is executed. A control packet carries a command code in byte 1 and that command's arguments after it. The dispatcher checks the argument count and the argument value for the command, applies its effect, and builds the reply in a small buffer of at most seven bytes.

The block holds a 32-bit time of day, counted in seconds since the start of 1904. It keeps this as an offset register added to a free-running count of elapsed seconds. A one-second tick, taken from a parameter that gives clock cycles per second, advances the elapsed count. Other outputs are the autopoll configuration (enable, period in milliseconds, 16-bit device mask), one-cycle power-down and system-reset strobes, and a one-cycle tag strobe for peripheral-bus packets. The block does not forward peripheral-bus packets; it only tags them.

Back-pressure rules: `in_ready` is high only while the block is idle. It drops from the cycle after the last input byte is accepted until the last reply byte has been accepted, or until the block decides that no reply is due. While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_len` hold their values. The source must present whole packets and must mark the final byte with `in_last`.

Top module: `ctl_pkt_dispatcher`

## Requirements
- R1: After reset `in_ready`=1, `out_valid`=0, `autopoll_en`=0, `poll_rate_ms`=20, `poll_mask`=16'hFFFF, and all strobes are 0.
- R2: A control command that passes its checks replies {8'h01, 8'h00, cmd} and then any result bytes. `out_len` gives the total reply length.
- R3: Each command needs an exact argument count: autopoll 1 (0x01), set-rate 1 (0x14), device-list 2 (0x19), power-down 0 (0x0A), reset 0 (0x11), file-server-flag 1 (0x13), power-messages 1 (0x0B), get-time 0 (0x03), set-time 4 (0x09). Any other count replies {8'h02, 8'h05, 8'h01, cmd} and has no effect.
- R4: A command code outside that set replies {8'h02, 8'h02, 8'h01, cmd}.
- R5: Autopoll sets `autopoll_en` to (argument != 0).
- R6: Set-rate stores its argument in `poll_rate_ms`. An argument of 0 is refused with the R3 bad-argument reply, and the rate keeps its value.
- R7: Device-list sets `poll_mask` to {arg0, arg1}, so the first argument byte becomes the high byte.
- R8: A valid power-down or reset command raises `power_down_pulse` or `system_reset_pulse` for exactly one cycle. A command with the wrong length raises neither strobe.
- R9: Get-time replies with 7 bytes. Bytes 3..6 hold offset+elapsed, most significant byte first. The offset resets to 2082844800, the 1904-based value of the 1970 epoch.
- R10: Set-time loads its big-endian 4-byte value minus the elapsed seconds into the offset, so a get-time that follows returns that value. The value advances by exactly k after k ticks.
- R11: File-server-flag and power-messages are acknowledged as in R2 and change no output.
- R12: Packets whose class is not control get no reply. Class 0 pulses `bus_pkt_pulse` once. A control packet with no command byte gets no reply.
- R13: While `out_valid`=1 and `out_ready`=0, the reply outputs hold. `in_ready` is 0 while a reply is pending.
- R14: Input bytes beyond the buffer depth are discarded but still counted, so an over-long packet gets the bad-argument reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | 8 | Input packet byte |
| in_last | input | 1 | Final byte of the packet |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Sink accepts the reply byte |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final reply byte |
| out_len | output | 3 | Total reply length in bytes |
| autopoll_en | output | 1 | Autopoll enabled |
| poll_rate_ms | output | 8 | Autopoll period in ms |
| poll_mask | output | 16 | Autopoll device mask |
| power_down_pulse | output | 1 | One-cycle power-down request |
| system_reset_pulse | output | 1 | One-cycle system reset request |
| bus_pkt_pulse | output | 1 | One-cycle tag for a peripheral-bus packet |

## Verification
The bench targets the length checks. It sends a power-down command that carries one argument, which a lax design would act on by firing the strobe. It sends a device-list command with one byte, which would corrupt the mask. It sends a packet longer than the buffer, which a design with a wrapping byte counter would read as a valid set-time. A zero set-rate argument must be refused, or the period would read zero. Time is checked across exactly three ticks and across a set/get pair, which exposes a swapped byte order or an offset that ignores the elapsed seconds. A reply held under back-pressure must stay still; a design that advanced its pointer on `out_valid` alone would drop bytes.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam logic [7:0] CLS_PERIPH = 8'h00;
  localparam logic [7:0] CLS_CTRL   = 8'h01;
  localparam logic [7:0] CLS_ERROR  = 8'h02;
  localparam logic [7:0] ERR_UNKNOWN = 8'h02;
  localparam logic [7:0] ERR_BADARG  = 8'h05;
  localparam int REPLY_MAX = 7;
  localparam int REPLY_LW  = $clog2(REPLY_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_SEND} disp_state_e;

  typedef struct packed {
    logic        en;
    logic [7:0]  rate;
    logic [15:0] mask;
  } poll_cfg_t;
endpackage

// File: rtl/pd_rx_collect.sv
module pd_rx_collect #(
  parameter int IN_BYTES = 8,
  parameter int LEN_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic [7:0]               data,
  input  logic                     clear,
  output logic [IN_BYTES-1:0][7:0] bytes,
  output logic [LEN_W-1:0]         count
);
  localparam logic [LEN_W-1:0] CNT_SAT = {LEN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (take && count != CNT_SAT) count <= count + 1'b1;
  end

  for (genvar g = 0; g < IN_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) bytes[g] <= '0;
      else if (take && count == LEN_W'(g)) bytes[g] <= data;
    end
  end
endmodule

// File: rtl/pd_sec_clock.sv
module pd_sec_clock #(
  parameter int          TICK_CYCLES = 250_000_000,
  parameter logic [31:0] INIT_OFFSET = 32'd2082844800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_en,
  input  logic [31:0] set_val,
  output logic [31:0] now_sec
);
  localparam int DIV_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(TICK_CYCLES - 1);

  logic [DIV_W-1:0] div_q;
  logic [31:0]      elapsed_q;
  logic [31:0]      offset_q;
  logic             tick;

  assign tick = (div_q == DIV_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      elapsed_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) elapsed_q <= elapsed_q + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) offset_q <= INIT_OFFSET;
    else if (set_en) offset_q <= set_val - elapsed_q;
  end

  assign now_sec = offset_q + elapsed_q;
endmodule

// File: rtl/pd_cmd_exec.sv
module pd_cmd_exec
  import pd_pkg::*;
#(
  parameter int         IN_BYTES   = 8,
  parameter int         LEN_W      = 4,
  parameter logic [7:0] RATE_RESET = 8'd20,
  parameter logic [7:0] C_AUTOPOLL = 8'h01,
  parameter logic [7:0] C_GETTIME  = 8'h03,
  parameter logic [7:0] C_SETTIME  = 8'h09,
  parameter logic [7:0] C_PWRDOWN  = 8'h0A,
  parameter logic [7:0] C_PWRMSG   = 8'h0B,
  parameter logic [7:0] C_SYSRST   = 8'h11,
  parameter logic [7:0] C_FSFLAG   = 8'h13,
  parameter logic [7:0] C_SETRATE  = 8'h14,
  parameter logic [7:0] C_DEVLIST  = 8'h19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,
  input  logic [IN_BYTES-1:0][7:0]  pkt,
  input  logic [LEN_W-1:0]          pkt_len,
  input  logic [31:0]               now_sec,
  output logic                      rep_has,
  output logic [REPLY_MAX-1:0][7:0] rep_bytes,
  output logic [REPLY_LW-1:0]       rep_len,
  output logic                      time_set_en,
  output logic [31:0]               time_set_val,
  output poll_cfg_t                 cfg,
  output logic                      pwr_down,
  output logic                      sys_rst,
  output logic                      bus_tag
);
  logic [7:0]       cls, cmd;
  logic             known, len_ok, arg_ok;
  logic [LEN_W-1:0] need;
  logic             act_poll, act_rate, act_mask, act_pd, act_rst, act_time;

  assign cls = pkt[0];
  assign cmd = pkt[1];

  always_comb begin
    known = 1'b1;
    need  = '0;
    case (cmd)
      C_AUTOPOLL: need = LEN_W'(1);
      C_SETRATE:  need = LEN_W'(1);
      C_DEVLIST:  need = LEN_W'(2);
      C_PWRDOWN:  need = LEN_W'(0);
      C_SYSRST:   need = LEN_W'(0);
      C_FSFLAG:   need = LEN_W'(1);
      C_PWRMSG:   need = LEN_W'(1);
      C_GETTIME:  need = LEN_W'(0);
      C_SETTIME:  need = LEN_W'(4);
      default:    known = 1'b0;
    endcase
  end

  assign len_ok = (pkt_len == need + LEN_W'(2));
  assign arg_ok = !(cmd == C_SETRATE && pkt[2] == 8'h00);

  always_comb begin
    rep_has   = 1'b0;
    rep_len   = '0;
    rep_bytes = '0;
    act_poll  = 1'b0;
    act_rate  = 1'b0;
    act_mask  = 1'b0;
    act_pd    = 1'b0;
    act_rst   = 1'b0;
    act_time  = 1'b0;
    if (pkt_len >= LEN_W'(2) && cls == CLS_CTRL) begin
      rep_has = 1'b1;
      if (!known) begin
        rep_bytes[0] = CLS_ERROR;
        rep_bytes[1] = ERR_UNKNOWN;
        rep_bytes[2] = CLS_CTRL;
        rep_bytes[3] = cmd;
        rep_len      = REPLY_LW'(4);
      end else if (!len_ok || !arg_ok) begin
        rep_bytes[0] = CLS_ERROR;
        rep_bytes[1] = ERR_BADARG;
        rep_bytes[2] = CLS_CTRL;
        rep_bytes[3] = cmd;
        rep_len      = REPLY_LW'(4);
      end else begin
        rep_bytes[0] = CLS_CTRL;
        rep_bytes[1] = 8'h00;
        rep_bytes[2] = cmd;
        rep_len      = REPLY_LW'(3);
        act_poll = (cmd == C_AUTOPOLL);
        act_rate = (cmd == C_SETRATE);
        act_mask = (cmd == C_DEVLIST);
        act_pd   = (cmd == C_PWRDOWN);
        act_rst  = (cmd == C_SYSRST);
        act_time = (cmd == C_SETTIME);
        if (cmd == C_GETTIME) begin
          rep_bytes[3] = now_sec[31:24];
          rep_bytes[4] = now_sec[23:16];
          rep_bytes[5] = now_sec[15:8];
          rep_bytes[6] = now_sec[7:0];
          rep_len      = REPLY_LW'(7);
        end
      end
    end
  end

  assign time_set_en  = fire && act_time;
  assign time_set_val = {pkt[2], pkt[3], pkt[4], pkt[5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.en   <= 1'b0;
      cfg.rate <= RATE_RESET;
      cfg.mask <= 16'hFFFF;
      pwr_down <= 1'b0;
      sys_rst  <= 1'b0;
      bus_tag  <= 1'b0;
    end else begin
      pwr_down <= fire && act_pd;
      sys_rst  <= fire && act_rst;
      bus_tag  <= fire && pkt_len != '0 && cls == CLS_PERIPH;
      if (fire && act_poll) cfg.en   <= (pkt[2] != 8'h00);
      if (fire && act_rate) cfg.rate <= pkt[2];
      if (fire && act_mask) cfg.mask <= {pkt[2], pkt[3]};
    end
  end
endmodule

// File: rtl/pd_reply_tx.sv
module pd_reply_tx
  import pd_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [REPLY_MAX-1:0][7:0] src,
  input  logic [REPLY_LW-1:0]       src_len,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [7:0]                out_data,
  output logic                      out_last,
  output logic [REPLY_LW-1:0]       out_len,
  output logic                      done
);
  logic [REPLY_MAX-1:0][7:0] buf_q;
  logic [REPLY_LW-1:0]       idx_q;

  assign out_last = out_valid && (idx_q == out_len - 1'b1);
  assign out_data = buf_q[idx_q];
  assign done     = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      idx_q     <= '0;
      out_len   <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      buf_q     <= src;
      idx_q     <= '0;
      out_len   <= src_len;
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      if (out_last) out_valid <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_pkt_dispatcher.sv
module ctl_pkt_dispatcher
  import pd_pkg::*;
#(
  parameter int          TICK_CYCLES = 250_000_000,
  parameter int          IN_BYTES    = 8,
  parameter logic [31:0] INIT_OFFSET = 32'd2082844800,
  parameter logic [7:0]  RATE_RESET  = 8'd20,
  parameter logic [7:0]  C_AUTOPOLL  = 8'h01,
  parameter logic [7:0]  C_GETTIME   = 8'h03,
  parameter logic [7:0]  C_SETTIME   = 8'h09,
  parameter logic [7:0]  C_PWRDOWN   = 8'h0A,
  parameter logic [7:0]  C_PWRMSG    = 8'h0B,
  parameter logic [7:0]  C_SYSRST    = 8'h11,
  parameter logic [7:0]  C_FSFLAG    = 8'h13,
  parameter logic [7:0]  C_SETRATE   = 8'h14,
  parameter logic [7:0]  C_DEVLIST   = 8'h19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic [2:0]  out_len,
  output logic        autopoll_en,
  output logic [7:0]  poll_rate_ms,
  output logic [15:0] poll_mask,
  output logic        power_down_pulse,
  output logic        system_reset_pulse,
  output logic        bus_pkt_pulse
);
  localparam int LEN_W = $clog2(IN_BYTES + 2);

  disp_state_e               state_q;
  logic                      take, fire, tx_done;
  logic [IN_BYTES-1:0][7:0]  pkt;
  logic [LEN_W-1:0]          pkt_len;
  logic [31:0]               now_sec, set_val;
  logic                      set_en, rep_has;
  logic [REPLY_MAX-1:0][7:0] rep_bytes;
  logic [REPLY_LW-1:0]       rep_len, len_w;
  poll_cfg_t                 cfg;

  assign in_ready = (state_q == ST_IDLE);
  assign take     = in_valid && in_ready;
  assign fire     = (state_q == ST_EXEC);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE: if (take && in_last) state_q <= ST_EXEC;
        ST_EXEC: state_q <= rep_has ? ST_SEND : ST_IDLE;
        ST_SEND: if (tx_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  pd_rx_collect #(.IN_BYTES(IN_BYTES), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .take(take), .data(in_data), .clear(fire),
    .bytes(pkt), .count(pkt_len));

  pd_sec_clock #(.TICK_CYCLES(TICK_CYCLES), .INIT_OFFSET(INIT_OFFSET)) u_clk (
    .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_val(set_val),
    .now_sec(now_sec));

  pd_cmd_exec #(
    .IN_BYTES(IN_BYTES), .LEN_W(LEN_W), .RATE_RESET(RATE_RESET),
    .C_AUTOPOLL(C_AUTOPOLL), .C_GETTIME(C_GETTIME), .C_SETTIME(C_SETTIME),
    .C_PWRDOWN(C_PWRDOWN), .C_PWRMSG(C_PWRMSG), .C_SYSRST(C_SYSRST),
    .C_FSFLAG(C_FSFLAG), .C_SETRATE(C_SETRATE), .C_DEVLIST(C_DEVLIST)
  ) u_exec (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pkt(pkt), .pkt_len(pkt_len),
    .now_sec(now_sec), .rep_has(rep_has), .rep_bytes(rep_bytes),
    .rep_len(rep_len), .time_set_en(set_en), .time_set_val(set_val),
    .cfg(cfg), .pwr_down(power_down_pulse), .sys_rst(system_reset_pulse),
    .bus_tag(bus_pkt_pulse));

  pd_reply_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(fire && rep_has), .src(rep_bytes),
    .src_len(rep_len), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_len(len_w),
    .done(tx_done));

  assign out_len      = 3'(len_w);
  assign autopoll_en  = cfg.en;
  assign poll_rate_ms = cfg.rate;
  assign poll_mask    = cfg.mask;
endmodule

// File: rtl/pd_disp_chk.sv
module pd_disp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic [2:0] out_len,
  input logic [7:0] poll_rate_ms,
  input logic       power_down_pulse,
  input logic       system_reset_pulse
);
  logic first_q;
  always_ff @(posedge clk) begin
    if (!rst_n) first_q <= 1'b1;
    else if (out_valid && out_ready) first_q <= out_last;
  end

  p_hold_data_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  p_hold_len_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && out_last) |=> $stable(out_len));
  p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_pd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    power_down_pulse |=> !power_down_pulse);
  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    system_reset_pulse |=> !system_reset_pulse);
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(power_down_pulse && system_reset_pulse));
  p_rate_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rate_ms != 8'h00);
  p_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && first_q |-> (out_data == 8'h01 || out_data == 8'h02));
endmodule

bind ctl_pkt_dispatcher pd_disp_chk u_disp_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .out_len(out_len), .poll_rate_ms(poll_rate_ms),
  .power_down_pulse(power_down_pulse), .system_reset_pulse(system_reset_pulse));

// File: tb/tb_ctl_pkt_dispatcher.sv
module tb_ctl_pkt_dispatcher;
  localparam int TICK = 1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_last, autopoll_en;
  logic [7:0]  out_data, poll_rate_ms;
  logic [2:0]  out_len;
  logic [15:0] poll_mask;
  logic        power_down_pulse, system_reset_pulse, bus_pkt_pulse;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int pd_cnt = 0, rs_cnt = 0, bus_cnt = 0;
  logic [7:0] pk [16];
  logic [7:0] rb [16];
  logic [7:0] ex [16];
  int rn, rlen;

  always #2 clk = ~clk;

  ctl_pkt_dispatcher #(.TICK_CYCLES(TICK)) dut (.*);

  always @(negedge clk) begin
    cyc++;
    if (rst_n && power_down_pulse) pd_cnt++;
    if (rst_n && system_reset_pulse) rs_cnt++;
    if (rst_n && bus_pkt_pulse) bus_cnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = pk[i]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic collect();
    int w = 0;
    rn = 0; rlen = 0; out_ready = 1'b1;
    while (w < 30) begin
      if (out_valid) begin
        if (rn == 0) rlen = out_len;
        rb[rn] = out_data; rn++;
        if (out_last) begin
          @(negedge clk);
          break;
        end
      end
      w++;
      @(negedge clk);
    end
  endtask

  task automatic xact(input int n);
    send(n);
    collect();
  endtask

  task automatic check_reply(input string req, input int n);
    chk({req, " reply count"}, rn, n);
    chk({req, " out_len"}, rlen, n);
    for (int i = 0; i < n && i < rn; i++) chk({req, " reply byte"}, rb[i], ex[i]);
  endtask

  task automatic set_ex(input logic [7:0] a, b, c, d);
    ex[0] = a; ex[1] = b; ex[2] = c; ex[3] = d;
  endtask

  function automatic logic [31:0] rtime();
    return {rb[3], rb[4], rb[5], rb[6]};
  endfunction

  task automatic t_reset();  // R1
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 autopoll", autopoll_en, 0);
    chk("R1 rate", poll_rate_ms, 20);
    chk("R1 mask", poll_mask, 16'hFFFF);
    chk("R1 strobes", {power_down_pulse, system_reset_pulse, bus_pkt_pulse}, 0);
  endtask

  task automatic t_gettime_reset();  // R9, R2
    pk[0] = 8'h01; pk[1] = 8'h03;
    xact(2);
    set_ex(8'h01, 8'h00, 8'h03, 8'h7C);
    ex[4] = 8'h25; ex[5] = 8'hB0; ex[6] = 8'h80;
    check_reply("R9 R2 get-time", 7);
  endtask

  task automatic t_autopoll();  // R5
    pk[0] = 8'h01; pk[1] = 8'h01; pk[2] = 8'h07;
    xact(3);
    set_ex(8'h01, 8'h00, 8'h01, 8'h00);
    check_reply("R5 R2 autopoll on", 3);
    chk("R5 autopoll enabled", autopoll_en, 1);
    pk[2] = 8'h00;
    xact(3);
    chk("R5 autopoll disabled", autopoll_en, 0);
  endtask

  task automatic t_rate();  // R6
    pk[0] = 8'h01; pk[1] = 8'h14; pk[2] = 8'd50;
    xact(3);
    set_ex(8'h01, 8'h00, 8'h14, 8'h00);
    check_reply("R6 set rate", 3);
    chk("R6 rate stored", poll_rate_ms, 50);
    pk[2] = 8'h00;
    xact(3);
    set_ex(8'h02, 8'h05, 8'h01, 8'h14);
    check_reply("R6 zero rate refused", 4);
    chk("R6 rate kept", poll_rate_ms, 50);
  endtask

  task automatic t_mask();  // R7
    pk[0] = 8'h01; pk[1] = 8'h19; pk[2] = 8'hA5; pk[3] = 8'h3C;
    xact(4);
    set_ex(8'h01, 8'h00, 8'h19, 8'h00);
    check_reply("R7 device list", 3);
    chk("R7 mask order", poll_mask, 16'hA53C);
  endtask

  task automatic t_power();  // R8
    int p0 = pd_cnt, r0 = rs_cnt;
    pk[0] = 8'h01; pk[1] = 8'h0A;
    xact(2);
    set_ex(8'h01, 8'h00, 8'h0A, 8'h00);
    check_reply("R8 power-down", 3);
    chk("R8 one pd pulse", pd_cnt - p0, 1);
    pk[1] = 8'h11;
    xact(2);
    chk("R8 one reset pulse", rs_cnt - r0, 1);
    chk("R8 no pd on reset", pd_cnt - p0, 1);
  endtask

  task automatic t_wrong_len();  // R3
    int p0 = pd_cnt;
    pk[0] = 8'h01; pk[1] = 8'h0A; pk[2] = 8'h00;
    xact(3);
    set_ex(8'h02, 8'h05, 8'h01, 8'h0A);
    check_reply("R3 power-down with arg", 4);
    chk("R3 R8 no pd pulse", pd_cnt - p0, 0);
    pk[1] = 8'h19; pk[2] = 8'h11;
    xact(3);
    set_ex(8'h02, 8'h05, 8'h01, 8'h19);
    check_reply("R3 short device list", 4);
    chk("R3 mask unchanged", poll_mask, 16'hA53C);
  endtask

  task automatic t_unknown();  // R4
    pk[0] = 8'h01; pk[1] = 8'h42; pk[2] = 8'h00;
    xact(3);
    set_ex(8'h02, 8'h02, 8'h01, 8'h42);
    check_reply("R4 unknown cmd", 4);
  endtask

  task automatic t_noeffect();  // R11
    pk[0] = 8'h01; pk[1] = 8'h13; pk[2] = 8'hFF;
    xact(3);
    set_ex(8'h01, 8'h00, 8'h13, 8'h00);
    check_reply("R11 file-server flag", 3);
    pk[1] = 8'h0B;
    xact(3);
    set_ex(8'h01, 8'h00, 8'h0B, 8'h00);
    check_reply("R11 power messages", 3);
    chk("R11 cfg untouched", {autopoll_en, poll_rate_ms, poll_mask}, {1'b0, 8'd50, 16'hA53C});
  endtask

  task automatic t_other_class();  // R12
    int b0 = bus_cnt;
    pk[0] = 8'h00; pk[1] = 8'h2C;
    xact(2);
    chk("R12 no reply class 0", rn, 0);
    chk("R12 bus tag", bus_cnt - b0, 1);
    pk[0] = 8'h04; pk[1] = 8'h03;
    xact(2);
    chk("R12 no reply class 4", rn, 0);
    pk[0] = 8'h01;
    xact(1);
    chk("R12 no reply bare control", rn, 0);
    chk("R12 idle again", in_ready, 1);
    chk("R12 single bus tag", bus_cnt - b0, 1);
  endtask

  task automatic t_settime();  // R10
    logic [31:0] t;
    pk[0] = 8'h01; pk[1] = 8'h09;
    pk[2] = 8'h12; pk[3] = 8'h34; pk[4] = 8'h56; pk[5] = 8'h78;
    xact(6);
    set_ex(8'h01, 8'h00, 8'h09, 8'h00);
    check_reply("R10 set-time ack", 3);
    pk[1] = 8'h03;
    xact(2);
    t = rtime();
    chk("R10 time after set", (t == 32'h12345678 || t == 32'h12345679), 1);
  endtask

  task automatic t_elapsed();  // R10
    logic [31:0] t0;
    int c0;
    pk[0] = 8'h01; pk[1] = 8'h03;
    c0 = cyc;
    xact(2);
    t0 = rtime();
    while (cyc < c0 + 3 * TICK) @(negedge clk);
    xact(2);
    chk("R10 three ticks", rtime() - t0, 3);
  endtask

  task automatic t_backpressure();  // R13
    logic [7:0] d0;
    pk[0] = 8'h01; pk[1] = 8'h03;
    out_ready = 1'b0;
    send(2);
    repeat (2) @(negedge clk);
    chk("R13 valid held", out_valid, 1);
    chk("R13 in_ready low", in_ready, 0);
    d0 = out_data;
    repeat (4) @(negedge clk);
    chk("R13 data held", out_data, d0);
    chk("R13 first byte", d0, 8'h01);
    collect();
    chk("R13 all bytes after stall", rn, 7);
    chk("R13 ready after reply", in_ready, 1);
  endtask

  task automatic t_overlength();  // R14
    pk[0] = 8'h01; pk[1] = 8'h09;
    for (int i = 2; i < 16; i++) pk[i] = 8'(i);
    xact(16);
    set_ex(8'h02, 8'h05, 8'h01, 8'h09);
    check_reply("R14 over-long packet", 4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gettime_reset();
    t_autopoll();
    t_rate();
    t_mask();
    t_power();
    t_wrong_len();
    t_unknown();
    t_noeffect();
    t_other_class();
    t_settime();
    t_elapsed();
    t_backpressure();
    t_overlength();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule